// File: doc/BRIEF.md
# SONET B1 Section Parity Generator and Inserter

This block sits in the byte-wide transmit path of a twelve-tributary SONET section, one byte per clock. It keeps an even-parity BIP-8 code over every byte of a frame as it leaves the downstream scrambler. It then writes that code into the B1 slot of the following frame, before that frame reaches the scrambler. The code is a bitwise XOR of all bytes, so each code bit gives even parity over one bit lane.

Two position trackers follow the frame geometry. One runs on the unscrambled input, marked by `fp_i`. The other runs on the scrambled return stream, marked by `scr_fp_i`. The first tracker places the B1 slots. The second tells the accumulator where each scrambled frame starts and ends. Test equipment can force errors through a per-bit inversion mask, which acts only while fault insertion is enabled. Insertion as a whole can be switched off, in which case every B1 slot carries its input byte unchanged.

Top module: `sonet_b1_inserter`

## Requirements
- R1: While `rst_ni` is low, `dout_o` is 0 and `fp_o` is 0.
- R2: Every byte outside the B1 slots appears on `dout_o` one clock after it enters on `din_i`, unchanged. `fp_o` is `fp_i` delayed by one clock.
- R3: A frame is ROWS x ROW_BYTES bytes. Position 0 is the byte marked by the frame pulse. Position ROW_BYTES is the first byte of the second row and is the B1 byte of the first tributary. With insertion on and fault insertion off, that byte is replaced by the XOR of all bytes of the most recently completed scrambled frame on `scr_i`.
- R4: Until a scrambled frame has completed after reset, the code that is inserted is 8'h00.
- R5: With insertion on, positions ROW_BYTES+1 to ROW_BYTES+N_STS-1 (the other B1 slots) are output as 8'h00.
- R6: With insertion on and `fi_en_i` high, each bit set in `err_mask_i` inverts the matching bit of the inserted code. With `fi_en_i` low, the mask has no effect.
- R7: With `ins_en_i` low, all N_STS B1 slots pass `din_i` through unchanged.
- R8: When no frame pulse arrives, each position tracker wraps after ROWS x ROW_BYTES bytes and keeps its place. A pulse always restarts its tracker at position 0. A scrambled frame starts on its tracker's position 0, whether that position was reached by a pulse or by wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fp_i | input | 1 | Marks position 0 of the unscrambled input frame |
| din_i | input | DW | Unscrambled input byte |
| scr_fp_i | input | 1 | Marks position 0 of the scrambled return frame |
| scr_i | input | DW | Scrambled byte, used for accumulation |
| err_mask_i | input | DW | Per-bit inversion mask for the inserted code |
| fi_en_i | input | 1 | Fault insertion enable for the mask |
| ins_en_i | input | 1 | Enables writing of the B1 slots |
| fp_o | output | 1 | Frame pulse aligned with `dout_o` |
| dout_o | output | DW | Output byte with the B1 slots written |

## Verification
The assertions assume three things:
- The output is registered, which is the default.
- The enables and the mask are sampled in the same cycle as the byte they act on.
- The scrambled return stream lags the input by fewer than ROW_BYTES bytes, so each new code is latched before the next B1 slot is reached.

The stimulus keeps to these limits. It uses full-length frames and a fixed scrambler lag of three bytes. It drops frame pulses on both streams at random, so the trackers must wrap on their own. It also varies the enables and the mask from frame to frame, with directed frames covering the first frame after reset, a full-mask inversion, disabled insertion and an ignored mask.

// File: rtl/b1_pkg.sv
package b1_pkg;
   typedef enum logic [1:0] {
      SLOT_DATA = 2'd0,
      SLOT_B1   = 2'd1,
      SLOT_FILL = 2'd2
   } slot_e;
endpackage

// File: rtl/b1_frame_pos.sv
module b1_frame_pos #(
   parameter int ROW_BYTES = 1080,
   parameter int ROWS      = 9
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic                         sof_i,
   output logic [$clog2(ROW_BYTES)-1:0] col_o,
   output logic [$clog2(ROWS)-1:0]      row_o
);
   localparam int CW = $clog2(ROW_BYTES);
   localparam int RW = $clog2(ROWS);
   localparam logic [CW-1:0] COL_LAST = CW'(ROW_BYTES - 1);
   localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);

   logic [CW-1:0] col_q;
   logic [RW-1:0] row_q;

   // position of the byte present this cycle
   always_comb begin
      col_o = sof_i ? '0 : col_q;
      row_o = sof_i ? '0 : row_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         col_q <= '0;
         row_q <= '0;
      end else if (col_o == COL_LAST) begin
         col_q <= '0;
         row_q <= (row_o == ROW_LAST) ? '0 : row_o + 1'b1;
      end else begin
         col_q <= col_o + 1'b1;
         row_q <= row_o;
      end
   end
endmodule

// File: rtl/b1_bip_acc.sv
module b1_bip_acc #(
   parameter int DW = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          first_i,
   input  logic          last_i,
   input  logic [DW-1:0] d_i,
   output logic [DW-1:0] code_o
);
   logic [DW-1:0] acc_q;
   logic [DW-1:0] code_q;

   for (genvar b = 0; b < DW; b++) begin : g_lane
      logic lane_n;
      assign lane_n = first_i ? d_i[b] : (acc_q[b] ^ d_i[b]);
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            acc_q[b]  <= 1'b0;
            code_q[b] <= 1'b0;
         end else begin
            acc_q[b] <= lane_n;
            if (last_i) code_q[b] <= lane_n;
         end
      end
   end

   assign code_o = code_q;
endmodule

// File: rtl/b1_slot_mux.sv
module b1_slot_mux #(
   parameter int DW        = 8,
   parameter int ROW_BYTES = 1080,
   parameter int ROWS      = 9,
   parameter int N_STS     = 12
) (
   input  logic [$clog2(ROW_BYTES)-1:0] col_i,
   input  logic [$clog2(ROWS)-1:0]      row_i,
   input  logic [DW-1:0]                din_i,
   input  logic [DW-1:0]                code_i,
   input  logic [DW-1:0]                mask_i,
   input  logic                         fi_en_i,
   input  logic                         ins_en_i,
   output b1_pkg::slot_e                slot_o,
   output logic [DW-1:0]                dout_o
);
   import b1_pkg::*;
   localparam int CW = $clog2(ROW_BYTES);
   localparam int RW = $clog2(ROWS);
   localparam logic [CW-1:0] FILL_END = CW'(N_STS);

   logic [DW-1:0] b1_byte;

   always_comb begin
      slot_o = SLOT_DATA;
      if (row_i == RW'(1)) begin
         if (col_i == '0)           slot_o = SLOT_B1;
         else if (col_i < FILL_END) slot_o = SLOT_FILL;
      end
   end

   for (genvar b = 0; b < DW; b++) begin : g_inv
      assign b1_byte[b] = code_i[b] ^ (fi_en_i & mask_i[b]);
   end

   always_comb begin
      dout_o = din_i;
      if (ins_en_i) begin
         case (slot_o)
            SLOT_B1:   dout_o = b1_byte;
            SLOT_FILL: dout_o = '0;
            default:   dout_o = din_i;
         endcase
      end
   end
endmodule

// File: rtl/sonet_b1_inserter.sv
module sonet_b1_inserter #(
   parameter int DW        = 8,
   parameter int ROW_BYTES = 1080,
   parameter int ROWS      = 9,
   parameter int N_STS     = 12,
   parameter bit REG_OUT   = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          fp_i,
   input  logic [DW-1:0] din_i,
   input  logic          scr_fp_i,
   input  logic [DW-1:0] scr_i,
   input  logic [DW-1:0] err_mask_i,
   input  logic          fi_en_i,
   input  logic          ins_en_i,
   output logic          fp_o,
   output logic [DW-1:0] dout_o
);
   localparam int CW = $clog2(ROW_BYTES);
   localparam int RW = $clog2(ROWS);

   if (ROWS < 2) begin : g_bad_rows
      $error("ROWS must be at least 2");
   end
   if (N_STS < 1 || N_STS >= ROW_BYTES) begin : g_bad_sts
      $error("N_STS must lie in 1..ROW_BYTES-1");
   end
   if (DW < 1) begin : g_bad_dw
      $error("DW must be positive");
   end

   logic [CW-1:0]  in_col, scr_col;
   logic [RW-1:0]  in_row, scr_row;
   logic           scr_first, scr_last;
   logic [DW-1:0]  bip_code;
   logic [DW-1:0]  mux_byte;
   b1_pkg::slot_e  slot_kind;

   b1_frame_pos #(.ROW_BYTES(ROW_BYTES), .ROWS(ROWS)) u_in_pos (
      .clk_i(clk_i), .rst_ni(rst_ni), .sof_i(fp_i),
      .col_o(in_col), .row_o(in_row)
   );

   b1_frame_pos #(.ROW_BYTES(ROW_BYTES), .ROWS(ROWS)) u_scr_pos (
      .clk_i(clk_i), .rst_ni(rst_ni), .sof_i(scr_fp_i),
      .col_o(scr_col), .row_o(scr_row)
   );

   assign scr_first = (scr_col == '0) && (scr_row == '0);
   assign scr_last  = (scr_col == CW'(ROW_BYTES - 1)) && (scr_row == RW'(ROWS - 1));

   b1_bip_acc #(.DW(DW)) u_acc (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .first_i(scr_first), .last_i(scr_last),
      .d_i(scr_i), .code_o(bip_code)
   );

   b1_slot_mux #(.DW(DW), .ROW_BYTES(ROW_BYTES), .ROWS(ROWS), .N_STS(N_STS)) u_mux (
      .col_i(in_col), .row_i(in_row), .din_i(din_i),
      .code_i(bip_code), .mask_i(err_mask_i),
      .fi_en_i(fi_en_i), .ins_en_i(ins_en_i),
      .slot_o(slot_kind), .dout_o(mux_byte)
   );

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            fp_o   <= 1'b0;
            dout_o <= '0;
         end else begin
            fp_o   <= fp_i;
            dout_o <= mux_byte;
         end
      end
   end else begin : g_comb_out
      assign fp_o   = rst_ni & fp_i;
      assign dout_o = rst_ni ? mux_byte : '0;
   end
endmodule

// File: rtl/b1_ins_chk.sv
module b1_ins_chk #(
   parameter int DW      = 8,
   parameter bit REG_OUT = 1'b1
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          fp_i,
   input logic [DW-1:0] din_i,
   input logic [DW-1:0] err_mask_i,
   input logic          fi_en_i,
   input logic          ins_en_i,
   input logic          fp_o,
   input logic [DW-1:0] dout_o,
   input logic [DW-1:0] code_i,
   input b1_pkg::slot_e slot_i
);
   import b1_pkg::*;

   always_comb begin
      if (!rst_ni) begin
         AST_RESET_QUIET: assert (dout_o == '0 && fp_o == 1'b0); // R1
      end
   end

   if (REG_OUT) begin : g_seq
      AST_PULSE_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $past(rst_ni) |-> fp_o == $past(fp_i)); // R2

      AST_FILL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($past(rst_ni) && $past(ins_en_i) && $past(slot_i) == SLOT_FILL) |-> dout_o == '0); // R5

      AST_PASS_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($past(rst_ni) && !$past(ins_en_i)) |-> dout_o == $past(din_i)); // R7

      AST_CODE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($past(rst_ni) && $past(ins_en_i) && !$past(fi_en_i) && $past(slot_i) == SLOT_B1)
         |-> dout_o == $past(code_i)); // R3

      AST_CODE_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($past(rst_ni) && $past(ins_en_i) && $past(fi_en_i) && $past(slot_i) == SLOT_B1)
         |-> dout_o == ($past(code_i) ^ $past(err_mask_i))); // R6

      AST_DATA_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($past(rst_ni) && $past(slot_i) == SLOT_DATA) |-> dout_o == $past(din_i)); // R2
   end
endmodule

bind sonet_b1_inserter b1_ins_chk #(.DW(DW), .REG_OUT(REG_OUT)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .fp_i(fp_i), .din_i(din_i),
   .err_mask_i(err_mask_i), .fi_en_i(fi_en_i), .ins_en_i(ins_en_i),
   .fp_o(fp_o), .dout_o(dout_o), .code_i(bip_code), .slot_i(slot_kind)
);

// File: tb/sim_sonet_b1_inserter.sv
module sim_sonet_b1_inserter;
   localparam int CLK_PERIOD = 10;
   localparam int ROWB   = 48;
   localparam int NROWS  = 9;
   localparam int NSTS   = 12;
   localparam int FRAME  = ROWB * NROWS;
   localparam int LAT    = 3;
   localparam int NFRM   = 24;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fp_i = 1'b0, scr_fp_i = 1'b0;
   logic [7:0] din_i = '0, scr_i = '0, mask_i = '0;
   logic       fi_en_i = 1'b0, ins_en_i = 1'b0;
   logic       fp_o;
   logic [7:0] dout_o;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sonet_b1_inserter #(.DW(8), .ROW_BYTES(ROWB), .ROWS(NROWS), .N_STS(NSTS)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .fp_i(fp_i), .din_i(din_i),
      .scr_fp_i(scr_fp_i), .scr_i(scr_i), .err_mask_i(mask_i),
      .fi_en_i(fi_en_i), .ins_en_i(ins_en_i), .fp_o(fp_o), .dout_o(dout_o)
   );

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic logic [7:0] exp_byte(input int p, input logic [7:0] d,
                                           input logic [7:0] code, input logic [7:0] m,
                                           input bit fi, input bit ins);
      if (!ins) return d;
      if (p == ROWB) return fi ? (code ^ m) : code;
      if (p > ROWB && p < ROWB + NSTS) return 8'h00;
      return d;
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] code_m, acc_m, e;
      int spos;
      bit fp_keep, sfp_keep, frame_nofp;
      string tag;
      void'($urandom(32'h1B1B));
      code_m = 8'h00;
      acc_m  = 8'h00;
      spos   = 0;
      fp_keep = 1'b1;
      sfp_keep = 1'b1;
      frame_nofp = 1'b0;

      // R1: outputs held quiet during reset with busy inputs
      din_i = 8'hA5; fp_i = 1'b1; ins_en_i = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 dout", dout_o, 8'h00);
      chk("R1 fp", {7'd0, fp_o}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;

      for (int c = 0; c < NFRM * FRAME; c++) begin
         int p, f;
         p = c % FRAME;
         f = c / FRAME;
         if (p == 0) begin
            case (f)
               0: begin ins_en_i = 1; fi_en_i = 0; mask_i = 8'h3C; fp_keep = 1; end // R4
               1: begin ins_en_i = 1; fi_en_i = 1; mask_i = 8'hFF; fp_keep = 1; end // R6
               2: begin ins_en_i = 0; fi_en_i = 1; mask_i = 8'h81; fp_keep = 0; end // R7, R8
               3: begin ins_en_i = 1; fi_en_i = 0; mask_i = 8'hFF; fp_keep = 1; end // R6 ignored
               default: begin
                  ins_en_i = ($urandom % 5) != 0;
                  fi_en_i  = ($urandom % 3) == 0;
                  mask_i   = 8'($urandom);
                  fp_keep  = ($urandom % 4) != 0;
               end
            endcase
            frame_nofp = !fp_keep;
         end
         if (c >= LAT && ((c - LAT) % FRAME) == 0)
            sfp_keep = (f < 4) || (($urandom % 4) != 0);
         fp_i     = (p == 0) && fp_keep;
         scr_fp_i = (c >= LAT) && (((c - LAT) % FRAME) == 0) && sfp_keep;
         din_i    = 8'($urandom);
         scr_i    = 8'($urandom);

         e = exp_byte(p, din_i, code_m, mask_i, fi_en_i, ins_en_i);
         if (p == ROWB && ins_en_i) begin
            if (frame_nofp)   tag = "R8 B1 after wrap";
            else if (f == 0)  tag = "R4 first-frame code";
            else if (fi_en_i) tag = "R6 masked code";
            else              tag = "R3 parity code";
         end else if (p > ROWB && p < ROWB + NSTS) begin
            tag = ins_en_i ? "R5 fill slot" : "R7 slot passthrough";
         end else if (p == ROWB) begin
            tag = "R7 B1 passthrough";
         end else begin
            tag = "R2 data";
         end

         @(posedge clk);
         #1;
         chk(tag, dout_o, e);
         chk("R2 pulse", {7'd0, fp_o}, {7'd0, fp_i});

         // scrambled-side model (R3, R8)
         if (scr_fp_i) spos = 0;
         acc_m = (spos == 0) ? scr_i : (acc_m ^ scr_i);
         if (spos == FRAME - 1) code_m = acc_m;
         spos = (spos == FRAME - 1) ? 0 : spos + 1;

         @(negedge clk);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule